// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block sequences instructions through a small pipeline that has several independent functional units (for example an integer unit, an adder, a multiplier and a divider). A decoder hands it one decoded instruction at a time. Each instruction carries the index of the unit it needs, a destination register and two source registers. The controller never computes anything itself. It decides, for each unit, when that unit may take an instruction, when it may read its operands from the register file, and when it may write its result back. The units report the end of execution with a one-cycle done pulse, so unit latencies stay outside the controller.

Instructions are accepted strictly in program order. An accepted instruction then waits inside its unit until its sources are valid. Units waiting for operands are independent of each other, so a later instruction with ready sources can read, execute and finish before an earlier one. Out-of-order completion creates two further hazards. The first is an overwrite of a register that an earlier instruction still has to read, and the block delays such a write. The second is two writes to the same register finishing in the wrong order, and the block refuses to accept the second instruction until the first has written. The block keeps a status record for each unit and a result-status table that records, for each register, which unit will produce it.

The register file sees a read strobe and two source addresses per unit, plus a single write strobe with the destination address and the index of the unit whose result should be written.

Top module: `sb_ctrl`

## Requirements
- R1: After reset no unit is busy, no read or write strobe is active, and `in_ready` is high for an instruction that names any existing unit.
- R2: An instruction is accepted in a cycle where `in_valid` and `in_ready` are both high, at most one per cycle. While `in_ready` is low, the presented instruction and everything behind it wait.
- R3: `in_ready` is low while the unit selected by `in_fu` (unit index i, bit i of the unit vectors) is busy. This includes the cycle in which that unit writes. It is high again from the following cycle if no other hazard applies.
- R4: `in_ready` is low while any accepted, unfinished instruction has the same destination register as the presented one, and the write cycle of that instruction counts as unfinished.
- R5: A unit whose sources are both available raises `rd_en[i]` for exactly one cycle, the cycle after acceptance at the earliest. During that cycle it drives its source registers on `rd_addr1[i*REG_W +: REG_W]` and `rd_addr2[i*REG_W +: REG_W]`.
- R6: A source is unavailable while an earlier unfinished instruction will write that register. The waiting unit reads in the cycle after that write. This includes an instruction accepted in the same cycle as the write.
- R7: A unit whose sources are available reads even while an earlier-accepted unit is still waiting for its operands.
- R8: `fu_done[i]` counts only after unit i has read its operands. Before that, or when the unit is idle, it has no effect. The result becomes eligible for writing in the cycle after the counted pulse.
- R9: An eligible unit does not write while any other unit that has not yet read its operands has a valid source equal to that unit's destination. It writes in the cycle after the last such read.
- R10: At most one write happens per cycle (`wr_en`, `wr_addr`, `wr_unit`). When several units are eligible in the same cycle, the lowest index writes first.
- R11: `fu_busy[i]` is high from the cycle after unit i accepts an instruction until the cycle after it writes its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_fu | input | FU_W | Index of the functional unit the instruction needs |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| fu_done | input | NUM_FU | Per-unit pulse marking end of execution |
| fu_busy | output | NUM_FU | Per-unit busy flag |
| rd_en | output | NUM_FU | Per-unit register-file read strobe (operand read, start of execution) |
| rd_addr1 | output | NUM_FU*REG_W | Per-unit first source address, unit i at bits i*REG_W upward |
| rd_addr2 | output | NUM_FU*REG_W | Per-unit second source address, same packing |
| wr_en | output | 1 | Register-file write strobe |
| wr_addr | output | REG_W | Register written this cycle |
| wr_unit | output | FU_W | Unit whose result is written this cycle |

## Verification
A corrupted unit record or result-status entry shows up quickly at the ports. A lost producer tag leaves a `rd_en` that never rises, or that rises one or more cycles too early. A stale result-status entry holds `in_ready` low against a destination that is already free. A wrong source comparison lets a write appear while a dependent unit has not yet read. The directed scenarios pin every strobe to an exact cycle, so any of these faults is caught within one to three cycles of the event that should have triggered the strobe.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
   // Life cycle of one functional-unit status record.
   typedef enum logic [1:0] {
      PH_IDLE,      // no instruction held
      PH_OPERANDS,  // accepted, waiting for both sources
      PH_EXEC,      // operands read, unit computing
      PH_RESULT     // done seen, waiting for write permission
   } fu_phase_e;
endpackage

// File: rtl/sb_fu_slot.sv
`timescale 1ns/1ps
module sb_fu_slot
   import sb_pkg::*;
#(
   parameter int REG_W = 4,
   parameter int FU_W  = 2,
   parameter int IDX   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_sel,
   input  logic [REG_W-1:0] iss_dst,
   input  logic [REG_W-1:0] iss_src1,
   input  logic [REG_W-1:0] iss_src2,
   input  logic [FU_W-1:0]  iss_q1,
   input  logic [FU_W-1:0]  iss_q2,
   input  logic             iss_r1,
   input  logic             iss_r2,
   input  logic             wr_en,
   input  logic [FU_W-1:0]  wr_unit,
   input  logic             unit_done,
   output logic             busy,
   output logic [REG_W-1:0] dst,
   output logic [REG_W-1:0] src1,
   output logic [REG_W-1:0] src2,
   output logic             r1,
   output logic             r2,
   output logic             rd_go,
   output logic             wr_req
);
   fu_phase_e        phase_q;
   logic [FU_W-1:0]  q1_q, q2_q;
   logic             wake1, wake2, granted;

   assign busy    = (phase_q != PH_IDLE);
   assign rd_go   = (phase_q == PH_OPERANDS) && r1 && r2;
   assign wr_req  = (phase_q == PH_RESULT);
   assign granted = wr_en && (wr_unit == FU_W'(IDX));
   assign wake1   = wr_en && (phase_q == PH_OPERANDS) && !r1 && (q1_q == wr_unit);
   assign wake2   = wr_en && (phase_q == PH_OPERANDS) && !r2 && (q2_q == wr_unit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         dst     <= '0;
         src1    <= '0;
         src2    <= '0;
         q1_q    <= '0;
         q2_q    <= '0;
         r1      <= 1'b0;
         r2      <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (issue_sel) begin
                  phase_q <= PH_OPERANDS;
                  dst     <= iss_dst;
                  src1    <= iss_src1;
                  src2    <= iss_src2;
                  q1_q    <= iss_q1;
                  q2_q    <= iss_q2;
                  r1      <= iss_r1;
                  r2      <= iss_r2;
               end
            end
            PH_OPERANDS: begin
               if (rd_go) begin
                  phase_q <= PH_EXEC;
                  r1      <= 1'b0;
                  r2      <= 1'b0;
               end else begin
                  if (wake1) r1 <= 1'b1;
                  if (wake2) r2 <= 1'b1;
               end
            end
            PH_EXEC: begin
               if (unit_done) phase_q <= PH_RESULT;
            end
            PH_RESULT: begin
               if (granted) phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sb_war_guard.sv
`timescale 1ns/1ps
module sb_war_guard #(
   parameter int NUM_FU = 4,
   parameter int REG_W  = 4
) (
   input  logic [REG_W-1:0]  dst  [NUM_FU],
   input  logic [REG_W-1:0]  src1 [NUM_FU],
   input  logic [REG_W-1:0]  src2 [NUM_FU],
   input  logic [NUM_FU-1:0] r1,
   input  logic [NUM_FU-1:0] r2,
   input  logic [NUM_FU-1:0] busy,
   output logic [NUM_FU-1:0] clear
);
   // A unit may overwrite its destination only when no other unit still
   // holds an unread, valid source naming that register.
   always_comb begin
      for (int i = 0; i < NUM_FU; i++) begin
         clear[i] = 1'b1;
         for (int u = 0; u < NUM_FU; u++) begin
            if (u != i && busy[u] &&
                ((r1[u] && src1[u] == dst[i]) || (r2[u] && src2[u] == dst[i])))
               clear[i] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/sb_wr_arb.sv
`timescale 1ns/1ps
module sb_wr_arb #(
   parameter int NUM_FU = 4,
   parameter int FU_W   = 2
) (
   input  logic [NUM_FU-1:0] req,
   output logic              grant_v,
   output logic [FU_W-1:0]   grant_id
);
   // Fixed priority: scanning downward leaves the lowest requester last.
   always_comb begin
      grant_v  = 1'b0;
      grant_id = '0;
      for (int i = NUM_FU - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant_v  = 1'b1;
            grant_id = FU_W'(i);
         end
      end
   end
endmodule

// File: rtl/sb_ctrl.sv
`timescale 1ns/1ps
module sb_ctrl #(
   parameter  int NUM_FU   = 4,
   parameter  int NUM_REGS = 16,
   localparam int FU_W     = $clog2(NUM_FU),
   localparam int REG_W    = $clog2(NUM_REGS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [FU_W-1:0]         in_fu,
   input  logic [REG_W-1:0]        in_dst,
   input  logic [REG_W-1:0]        in_src1,
   input  logic [REG_W-1:0]        in_src2,
   output logic                    in_ready,
   input  logic [NUM_FU-1:0]       fu_done,
   output logic [NUM_FU-1:0]       fu_busy,
   output logic [NUM_FU-1:0]       rd_en,
   output logic [NUM_FU*REG_W-1:0] rd_addr1,
   output logic [NUM_FU*REG_W-1:0] rd_addr2,
   output logic                    wr_en,
   output logic [REG_W-1:0]        wr_addr,
   output logic [FU_W-1:0]         wr_unit
);
   // Elaboration-time parameter checks
   if (NUM_FU < 2) begin : g_bad_fu
      $error("sb_ctrl: NUM_FU must be at least 2");
   end
   if (NUM_REGS < 2 || (1 << REG_W) != NUM_REGS) begin : g_bad_regs
      $error("sb_ctrl: NUM_REGS must be a power of two, at least 2");
   end

   // Result-status table: which unit will write each register
   logic [NUM_REGS-1:0] rs_v;
   logic [FU_W-1:0]     rs_id [NUM_REGS];

   // Per-unit record views
   logic [REG_W-1:0]  s_dst  [NUM_FU];
   logic [REG_W-1:0]  s_src1 [NUM_FU];
   logic [REG_W-1:0]  s_src2 [NUM_FU];
   logic [NUM_FU-1:0] s_r1, s_r2, s_wr_req, war_clear;

   logic              unit_ok, issue;
   logic              r1_init, r2_init;
   logic [FU_W-1:0]   q1_init, q2_init;

   // Unit index range check: only needed when the count is not a power of two
   if (NUM_FU == (1 << FU_W)) begin : g_fu_full
      assign unit_ok = 1'b1;
   end else begin : g_fu_part
      assign unit_ok = (int'(in_fu) < NUM_FU);
   end

   assign in_ready = unit_ok && !fu_busy[in_fu] && !rs_v[in_dst];
   assign issue    = in_valid && in_ready;

   // Producer tags and ready flags at acceptance; a result written in the
   // same cycle already counts as available.
   assign q1_init = rs_id[in_src1];
   assign q2_init = rs_id[in_src2];
   assign r1_init = !rs_v[in_src1] || (wr_en && wr_unit == rs_id[in_src1]);
   assign r2_init = !rs_v[in_src2] || (wr_en && wr_unit == rs_id[in_src2]);

   for (genvar i = 0; i < NUM_FU; i++) begin : g_slot
      sb_fu_slot #(.REG_W(REG_W), .FU_W(FU_W), .IDX(i)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .issue_sel (issue && in_fu == FU_W'(i)),
         .iss_dst   (in_dst),
         .iss_src1  (in_src1),
         .iss_src2  (in_src2),
         .iss_q1    (q1_init),
         .iss_q2    (q2_init),
         .iss_r1    (r1_init),
         .iss_r2    (r2_init),
         .wr_en     (wr_en),
         .wr_unit   (wr_unit),
         .unit_done (fu_done[i]),
         .busy      (fu_busy[i]),
         .dst       (s_dst[i]),
         .src1      (s_src1[i]),
         .src2      (s_src2[i]),
         .r1        (s_r1[i]),
         .r2        (s_r2[i]),
         .rd_go     (rd_en[i]),
         .wr_req    (s_wr_req[i])
      );
      assign rd_addr1[i*REG_W +: REG_W] = s_src1[i];
      assign rd_addr2[i*REG_W +: REG_W] = s_src2[i];
   end

   sb_war_guard #(.NUM_FU(NUM_FU), .REG_W(REG_W)) u_war (
      .dst   (s_dst),
      .src1  (s_src1),
      .src2  (s_src2),
      .r1    (s_r1),
      .r2    (s_r2),
      .busy  (fu_busy),
      .clear (war_clear)
   );

   sb_wr_arb #(.NUM_FU(NUM_FU), .FU_W(FU_W)) u_arb (
      .req      (s_wr_req & war_clear),
      .grant_v  (wr_en),
      .grant_id (wr_unit)
   );

   assign wr_addr = s_dst[wr_unit];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_v <= '0;
         for (int r = 0; r < NUM_REGS; r++) rs_id[r] <= '0;
      end else begin
         if (wr_en) rs_v[wr_addr] <= 1'b0;
         if (issue) begin
            rs_v[in_dst]  <= 1'b1;
            rs_id[in_dst] <= in_fu;
         end
      end
   end
endmodule

// File: rtl/sb_ctrl_chk.sv
`timescale 1ns/1ps
module sb_ctrl_chk #(
   parameter  int NUM_FU   = 4,
   parameter  int NUM_REGS = 16,
   localparam int FU_W     = $clog2(NUM_FU),
   localparam int REG_W    = $clog2(NUM_REGS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [FU_W-1:0]   in_fu,
   input logic [REG_W-1:0]  in_dst,
   input logic [REG_W-1:0]  in_src1,
   input logic [REG_W-1:0]  in_src2,
   input logic              in_ready,
   input logic [NUM_FU-1:0] fu_busy,
   input logic [NUM_FU-1:0] rd_en,
   input logic              wr_en,
   input logic [REG_W-1:0]  wr_addr,
   input logic [FU_W-1:0]   wr_unit
);
   // Shadow of accepted instructions, rebuilt from port activity only
   logic [NUM_FU-1:0] sh_busy, sh_pend, sh_old1, sh_old2;
   logic [REG_W-1:0]  sh_dst [NUM_FU];
   logic [REG_W-1:0]  sh_s1  [NUM_FU];
   logic [REG_W-1:0]  sh_s2  [NUM_FU];
   logic              waw_hit, war_hit, old1_now, old2_now;
   logic              acc;

   assign acc = in_valid && in_ready;

   always_comb begin
      waw_hit  = 1'b0;
      old1_now = 1'b1;
      old2_now = 1'b1;
      war_hit  = 1'b0;
      for (int w = 0; w < NUM_FU; w++) begin
         if (sh_busy[w] && sh_dst[w] == in_dst) waw_hit = 1'b1;
         if (sh_busy[w] && sh_dst[w] == in_src1 && !(wr_en && wr_unit == FU_W'(w)))
            old1_now = 1'b0;
         if (sh_busy[w] && sh_dst[w] == in_src2 && !(wr_en && wr_unit == FU_W'(w)))
            old2_now = 1'b0;
         if (sh_pend[w] && wr_unit != FU_W'(w) &&
             ((sh_old1[w] && sh_s1[w] == wr_addr) || (sh_old2[w] && sh_s2[w] == wr_addr)))
            war_hit = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_busy <= '0;
         sh_pend <= '0;
         sh_old1 <= '0;
         sh_old2 <= '0;
         for (int i = 0; i < NUM_FU; i++) begin
            sh_dst[i] <= '0;
            sh_s1[i]  <= '0;
            sh_s2[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < NUM_FU; i++) begin
            if (rd_en[i]) sh_pend[i] <= 1'b0;
            if (wr_en && sh_pend[i] && sh_s1[i] == wr_addr) sh_old1[i] <= 1'b1;
            if (wr_en && sh_pend[i] && sh_s2[i] == wr_addr) sh_old2[i] <= 1'b1;
         end
         if (wr_en) sh_busy[wr_unit] <= 1'b0;
         if (acc) begin
            sh_busy[in_fu] <= 1'b1;
            sh_pend[in_fu] <= 1'b1;
            sh_dst[in_fu]  <= in_dst;
            sh_s1[in_fu]   <= in_src1;
            sh_s2[in_fu]   <= in_src2;
            sh_old1[in_fu] <= old1_now;
            sh_old2[in_fu] <= old2_now;
         end
      end
   end

   assert_issue_unit_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> !fu_busy[in_fu]) else $error("R3: accepted into a busy unit");

   assert_no_waw_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && waw_hit) |-> !in_ready) else $error("R4: destination already pending");

   assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> fu_busy[$past(in_fu)]) else $error("R11: unit not busy after acceptance");

   assert_free_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !fu_busy[$past(wr_unit)]) else $error("R11: unit still busy after write");

   assert_no_early_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !war_hit) else $error("R9: register overwritten before it was read");

   assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (sh_busy[wr_unit] && !sh_pend[wr_unit])) else $error("R8: write before operand read");

   for (genvar i = 0; i < NUM_FU; i++) begin : g_unit
      assert_read_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en[i] |-> sh_pend[i]) else $error("R5: read without a pending instruction");

      assert_read_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en[i] |=> !rd_en[i]) else $error("R5: read strobe longer than one cycle");

      assert_sources_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en[i] |-> (sh_old1[i] && sh_old2[i])) else $error("R6: read before producer wrote");
   end
endmodule

bind sb_ctrl sb_ctrl_chk #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_fu    (in_fu),
   .in_dst   (in_dst),
   .in_src1  (in_src1),
   .in_src2  (in_src2),
   .in_ready (in_ready),
   .fu_busy  (fu_busy),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_unit  (wr_unit)
);

// File: tb/sb_ctrl_test.sv
`timescale 1ns/1ps
module sb_ctrl_test;
   localparam int NUM_FU   = 4;
   localparam int NUM_REGS = 16;
   localparam int FU_W     = $clog2(NUM_FU);
   localparam int REG_W    = $clog2(NUM_REGS);

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic [FU_W-1:0]         in_fu = '0;
   logic [REG_W-1:0]        in_dst = '0, in_src1 = '0, in_src2 = '0;
   logic                    in_ready;
   logic [NUM_FU-1:0]       fu_done = '0;
   logic [NUM_FU-1:0]       fu_busy, rd_en;
   logic [NUM_FU*REG_W-1:0] rd_addr1, rd_addr2;
   logic                    wr_en;
   logic [REG_W-1:0]        wr_addr;
   logic [FU_W-1:0]         wr_unit;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   sb_ctrl #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fu(in_fu),
      .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_ready(in_ready),
      .fu_done(fu_done), .fu_busy(fu_busy), .rd_en(rd_en),
      .rd_addr1(rd_addr1), .rd_addr2(rd_addr2),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_unit(wr_unit)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Advance one cycle: clear one-cycle inputs after the edge, settle at negedge
   task automatic tick();
      @(posedge clk);
      #0.5;
      in_valid = 1'b0;
      fu_done  = '0;
      @(negedge clk);
   endtask

   task automatic present(input int fu, input int d, input int s1, input int s2);
      in_valid = 1'b1;
      in_fu    = FU_W'(fu);
      in_dst   = REG_W'(d);
      in_src1  = REG_W'(s1);
      in_src2  = REG_W'(s2);
      #0.2;
   endtask

   function automatic int a1(input int i);
      return int'(rd_addr1[i*REG_W +: REG_W]);
   endfunction
   function automatic int a2(input int i);
      return int'(rd_addr2[i*REG_W +: REG_W]);
   endfunction

   task automatic chk_wr(input string req, input int unit, input int addr);
      chk(req, "wr_en", int'(wr_en), 1);
      chk(req, "wr_unit", int'(wr_unit), unit);
      chk(req, "wr_addr", int'(wr_addr), addr);
   endtask

   task automatic t_reset();
      present(0, 1, 2, 3);
      chk("R1", "in_ready after reset", int'(in_ready), 1);
      chk("R1", "fu_busy after reset", int'(fu_busy), 0);
      chk("R1", "rd_en after reset", int'(rd_en), 0);
      chk("R1", "wr_en after reset", int'(wr_en), 0);
      in_valid = 1'b0;
   endtask

   task automatic t_basic();
      present(0, 1, 2, 3);
      chk("R2", "accept into idle unit", int'(in_ready), 1);
      tick();
      chk("R11", "busy after accept", int'(fu_busy), 1);
      chk("R5", "read strobe", int'(rd_en), 1);
      chk("R5", "rd_addr1 unit0", a1(0), 2);
      chk("R5", "rd_addr2 unit0", a2(0), 3);
      tick();
      chk("R5", "read strobe single cycle", int'(rd_en), 0);
      fu_done[0] = 1'b1;
      #0.2;
      chk("R8", "no write in done cycle", int'(wr_en), 0);
      tick();
      chk_wr("R8", 0, 1);
      chk("R11", "busy during write", int'(fu_busy), 1);
      tick();
      chk("R11", "free after write", int'(fu_busy), 0);
      chk("R10", "no further write", int'(wr_en), 0);
   endtask

   task automatic t_struct();
      present(1, 4, 5, 6);
      tick();
      present(1, 7, 0, 0);
      chk("R3", "unit busy reading", int'(in_ready), 0);
      tick();
      fu_done[1] = 1'b1;
      present(1, 7, 0, 0);
      chk("R3", "unit busy executing", int'(in_ready), 0);
      tick();
      present(1, 7, 0, 0);
      chk("R3", "unit busy in write cycle", int'(in_ready), 0);
      chk_wr("R3", 1, 4);
      tick();
      present(1, 7, 0, 0);
      chk("R3", "unit free after write", int'(in_ready), 1);
      tick();
      chk("R5", "unit1 reads", int'(rd_en), 2);
      tick();
      fu_done[1] = 1'b1;
      tick();
      chk_wr("R8", 1, 7);
      tick();
   endtask

   task automatic t_waw();
      present(2, 5, 1, 2);
      tick();
      present(0, 5, 3, 4);
      chk("R4", "same dst pending, reading", int'(in_ready), 0);
      tick();
      fu_done[2] = 1'b1;
      present(0, 5, 3, 4);
      chk("R4", "same dst pending, executing", int'(in_ready), 0);
      tick();
      present(0, 5, 3, 4);
      chk("R4", "same dst pending, write cycle", int'(in_ready), 0);
      chk_wr("R4", 2, 5);
      tick();
      present(0, 5, 3, 4);
      chk("R4", "accept after write", int'(in_ready), 1);
      tick();
      chk("R5", "second writer reads", int'(rd_en), 1);
      tick();
      fu_done[0] = 1'b1;
      tick();
      chk_wr("R4", 0, 5);
      tick();
   endtask

   task automatic t_raw_overtake();
      present(2, 4, 1, 2);
      tick();
      chk("R5", "producer reads", int'(rd_en), 4);
      present(0, 5, 4, 3);
      tick();
      chk("R6", "consumer waits on r4", int'(rd_en), 0);
      present(1, 6, 7, 8);
      fu_done[0] = 1'b1;   // unit 0 has not read yet: ignored
      tick();
      chk("R7", "later unit reads first", int'(rd_en), 2);
      chk("R8", "early done ignored", int'(wr_en), 0);
      fu_done[2] = 1'b1;
      tick();
      chk_wr("R6", 2, 4);
      chk("R6", "consumer still waits in write cycle", int'(rd_en[0]), 0);
      fu_done[1] = 1'b1;
      tick();
      chk("R6", "consumer reads after write", int'(rd_en), 1);
      chk("R6", "consumer rd_addr1", a1(0), 4);
      chk_wr("R7", 1, 6);
      tick();
      chk("R8", "no write without real done", int'(wr_en), 0);
      fu_done[0] = 1'b1;
      tick();
      chk_wr("R6", 0, 5);
      tick();
   endtask

   task automatic t_war();
      present(3, 10, 11, 12);
      tick();
      present(2, 13, 10, 9);
      tick();
      chk("R6", "unit2 waits on r10", int'(rd_en[2]), 0);
      present(0, 9, 14, 15);
      tick();
      chk("R5", "unit0 reads", int'(rd_en), 1);
      tick();
      fu_done[0] = 1'b1;
      tick();
      chk("R9", "r9 write held, unit2 unread", int'(wr_en), 0);
      tick();
      chk("R9", "r9 write still held", int'(wr_en), 0);
      fu_done[3] = 1'b1;
      tick();
      chk_wr("R9", 3, 10);
      tick();
      chk("R6", "unit2 reads after r10 write", int'(rd_en), 4);
      chk("R9", "held during unit2 read cycle", int'(wr_en), 0);
      tick();
      chk_wr("R9", 0, 9);
      fu_done[2] = 1'b1;
      tick();
      chk_wr("R9", 2, 13);
      tick();
      chk("R11", "all idle", int'(fu_busy), 0);
   endtask

   task automatic t_priority();
      present(0, 2, 3, 4);
      tick();
      present(1, 6, 7, 8);
      tick();
      tick();
      fu_done = 4'b0011;
      tick();
      chk_wr("R10", 0, 2);
      tick();
      chk_wr("R10", 1, 6);
      tick();
      chk("R10", "no write left", int'(wr_en), 0);
   endtask

   task automatic t_same_cycle();
      present(2, 3, 1, 1);
      tick();
      tick();
      fu_done[2] = 1'b1;
      tick();
      chk_wr("R6", 2, 3);
      present(0, 4, 3, 0);
      chk("R2", "accept during producer write", int'(in_ready), 1);
      tick();
      chk("R6", "read right after same-cycle write", int'(rd_en), 1);
      tick();
      fu_done[0] = 1'b1;
      tick();
      chk_wr("R6", 0, 4);
      tick();
   endtask

   task automatic t_idle_done();
      fu_done = '1;
      tick();
      chk("R8", "idle done gives no write", int'(wr_en), 0);
      chk("R8", "idle done gives no busy", int'(fu_busy), 0);
      chk("R8", "idle done gives no read", int'(rd_en), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_struct();
      t_waw();
      t_raw_overtake();
      t_war();
      t_priority();
      t_same_cycle();
      t_idle_done();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule